// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block turns pairs of signed audio words (left and right) into a serial bit stream for a downstream receiver. Each channel takes a slot of bit-clock periods. The word goes out most significant bit first, and the rest of the slot is padded with zeros. The data line changes only after a falling edge of the bit clock, so the receiver can sample it on the rising edge.

In master mode the port makes the bit clock and the word select itself. It divides the system clock, which runs at 256 times the sample rate. In slave mode it follows a bit clock and word select driven from outside. These are resynchronised into the system clock domain. The outside bit clock may pause, held high, between channel bursts.

A layout input chooses whether the most significant bit shares its bit period with the word-select change or comes one bit later. An extra slave-only input reverses the word-select polarity. A standby input releases every pin driver. After reset, or when the port leaves standby, the data stays zero for a programmable number of frames while the upstream filter settles. One of two frame counts applies, depending on whether the high-pass filter is on.

Top module: `aud_ser_tx`

## Requirements
- R1: In master mode `bclk_out` has a period of DIV system clocks with DIV/2 high. `ws_out` changes only on a falling edge of `bclk_out`, once every SLOT_N bit-clock periods.
- R2: When its driver is enabled, `sd_out` changes only on the system clock edge at which the bit clock falls. In slave mode this is the sampled external falling edge.
- R3: With `fmt_sel`=1, the channel word occupies slots 0 to WORD_W-1 of the channel. Slot 0 is the bit period that starts with the word-select change. The word is sent most significant bit first.
- R4: With `fmt_sel`=0, slot 0 carries zero and the word occupies slots 1 to WORD_W, most significant bit first.
- R5: Every slot not holding a word bit carries zero.
- R6: Word select low marks the left channel and high marks the right channel. In slave mode with `ext_fmt`=1 the meaning is reversed. In master mode `ext_fmt` has no effect.
- R7: In slave mode the port shifts one bit per falling edge of `bclk_in` and tracks `ws_in`. Idle gaps with `bclk_in` held high between bursts leave the stream intact.
- R8: While `sleep` is high, `sd_oe`, `bclk_oe` and `ws_oe` are low from the next clock edge and `sd_out` is zero. During reset all three enables are low.
- R9: After reset or after `sleep` falls, each left-channel start is counted. Every channel that starts while that count is at most QUIET_SHORT (`hpf_on`=0) or QUIET_LONG (`hpf_on`=1) sends all zeros. The first channel after `sd_oe` rises is zero.
- R10: The word sent in a channel is the value of `left_in` or `right_in` for that channel, taken at the falling edge that starts the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | 1: generate bit clock and word select; 0: follow external ones |
| fmt_sel | input | 1 | 1: MSB in the word-select bit period; 0: MSB one bit later |
| ext_fmt | input | 1 | Slave only: 1 reverses word-select polarity |
| hpf_on | input | 1 | Chooses the long quiet period after wake-up |
| sleep | input | 1 | Standby request, active high |
| left_in | input | WORD_W | Left sample, two's complement |
| right_in | input | WORD_W | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Driver enable for the bit-clock pin |
| ws_out | output | 1 | Generated word select (master) |
| ws_oe | output | 1 | Driver enable for the word-select pin |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Driver enable for the serial data pin |

## Verification
The assertions assume that the mode, layout, polarity and filter inputs stay constant between resets. They also assume that in slave mode `ws_in` changes together with a falling `bclk_in`. Each `bclk_in` level must be held for more than SYNC_STAGES+1 system clocks, so that the synchroniser sees every edge. The bench changes these inputs only while reset is held, drives the external clock with eight system clocks per bit, and moves `ws_in` only at its falling edges. It refreshes each sample input while the other channel is being sent, so the value it expects is stable when the port captures it.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int unsigned MAX_WORD = 32;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // Value of one slot of a channel: the word MSB first, starting at slot 0
  // (aligned layout) or slot 1 (delayed layout); zero everywhere else.
  function automatic logic slot_bit(input logic [MAX_WORD-1:0] word,
                                    input int unsigned width,
                                    input int unsigned slot,
                                    input logic aligned);
    int unsigned first;
    first = aligned ? 0 : 1;
    if (slot < first || slot >= first + width) return 1'b0;
    return word[width - 1 - (slot - first)];
  endfunction

  // Channel carried by a word-select level, with optional polarity swap.
  function automatic chan_e chan_of(input logic ws, input logic swap);
    return chan_e'(ws ^ swap);
  endfunction

  // True once more frames than the quiet limit have started.
  function automatic logic past_quiet(input int unsigned seen,
                                      input int unsigned limit);
    return seen > limit;
  endfunction

endpackage

// File: rtl/aud_ser_mclk.sv
module aud_ser_mclk #(
  parameter int unsigned DIV    = 4,
  parameter int unsigned SLOT_N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic bclk,
  output logic ws,
  output logic tick,
  output logic ws_next
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned BW   = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HALF_V   = DW'(HALF);
  localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_N - 1);

  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q;

  // tick marks the system clock edge at which the bit clock falls
  assign tick    = (div_q == DIV_LAST);
  assign div_d   = tick ? '0 : div_q + 1'b1;
  assign ws_next = (bit_q == BIT_LAST) ? ~ws : ws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bclk  <= 1'b0;
      bit_q <= BIT_LAST;
      ws    <= 1'b1;
    end else if (clr) begin
      div_q <= '0;
      bclk  <= 1'b0;
      bit_q <= BIT_LAST;
      ws    <= 1'b1;
    end else begin
      div_q <= div_d;
      bclk  <= (div_d >= HALF_V);
      if (tick) begin
        bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
        ws    <= ws_next;
      end
    end
  end
endmodule

// File: rtl/aud_ser_edge.sv
module aud_ser_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic ws_in,
  output logic fall_tick,
  output logic ws_s
);
  logic [STAGES-1:0] bclk_sh;
  logic [STAGES-1:0] ws_sh;
  logic              bclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh   <= '1;
      ws_sh     <= '1;
      bclk_prev <= 1'b1;
    end else begin
      bclk_sh   <= {bclk_sh[STAGES-2:0], bclk_in};
      ws_sh     <= {ws_sh[STAGES-2:0], ws_in};
      bclk_prev <= bclk_sh[STAGES-1];
    end
  end

  // Both lines pass through equal depth, so a word-select change made with
  // the falling bit clock is visible in the same cycle as the fall.
  assign fall_tick = bclk_prev & ~bclk_sh[STAGES-1];
  assign ws_s      = ws_sh[STAGES-1];
endmodule

// File: rtl/aud_ser_slot.sv
module aud_ser_slot
  import aud_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned SLOT_N = 32,
  parameter int unsigned QW     = 11,
  localparam int unsigned CW    = $clog2(SLOT_N) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              ws_now,
  input  logic              swap,
  input  logic              aligned,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  input  logic [QW-1:0]     quiet_n,
  output logic              sd,
  output logic [CW-1:0]     slot_q
);
  localparam int unsigned MW = MAX_WORD;
  localparam logic [CW-1:0] SLOT_MAX = '1;
  localparam logic [QW-1:0] SEEN_MAX = '1;

  logic              ws_last;
  chan_e             chan_q, chan_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CW-1:0]     slot_d;
  logic [QW-1:0]     seen_q, seen_d;
  logic              live_q, live_d;
  logic              chg, bit_d;

  always_comb begin
    chg    = (ws_now != ws_last);
    chan_d = chg ? chan_of(ws_now, swap) : chan_q;
    word_d = chg ? ((chan_d == CH_RIGHT) ? right_in : left_in) : word_q;
    if (chg)                    slot_d = '0;
    else if (slot_q == SLOT_MAX) slot_d = slot_q;
    else                        slot_d = slot_q + 1'b1;
    seen_d = (chg && chan_d == CH_LEFT && seen_q != SEEN_MAX) ? seen_q + 1'b1 : seen_q;
    live_d = chg ? past_quiet(32'(seen_d), 32'(quiet_n)) : live_q;
    bit_d  = live_d & slot_bit(MW'(word_d), WORD_W, 32'(slot_d), aligned);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last <= 1'b1;
      chan_q  <= CH_RIGHT;
      word_q  <= '0;
      slot_q  <= SLOT_MAX;
      seen_q  <= '0;
      live_q  <= 1'b0;
      sd      <= 1'b0;
    end else if (clr) begin
      ws_last <= 1'b1;
      chan_q  <= CH_RIGHT;
      word_q  <= '0;
      slot_q  <= SLOT_MAX;
      seen_q  <= '0;
      live_q  <= 1'b0;
      sd      <= 1'b0;
    end else if (tick) begin
      ws_last <= ws_now;
      chan_q  <= chan_d;
      word_q  <= word_d;
      slot_q  <= slot_d;
      seen_q  <= seen_d;
      live_q  <= live_d;
      sd      <= bit_d;
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int unsigned WORD_W      = 18,
  parameter int unsigned SLOT_N      = 32,
  parameter int unsigned DIV         = 4,
  parameter int unsigned QUIET_SHORT = 1024,
  parameter int unsigned QUIET_LONG  = 12288,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              fmt_sel,
  input  logic              ext_fmt,
  input  logic              hpf_on,
  input  logic              sleep,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  input  logic              bclk_in,
  input  logic              ws_in,
  output logic              bclk_out,
  output logic              bclk_oe,
  output logic              ws_out,
  output logic              ws_oe,
  output logic              sd_out,
  output logic              sd_oe
);
  localparam int unsigned QW = $clog2(QUIET_LONG + 2);
  localparam int unsigned CW = $clog2(SLOT_N) + 1;
  localparam logic [QW-1:0] Q_SHORT = QW'(QUIET_SHORT);
  localparam logic [QW-1:0] Q_LONG  = QW'(QUIET_LONG);

  // Named internal events, also observed by the bound checker
  logic          m_tick, m_ws_next, m_bclk, m_ws;
  logic          s_tick, s_ws;
  logic          bit_tick, ws_now, swap_pol;
  logic [CW-1:0] trk_slot;
  logic          pin_clk_oe, pin_sd_oe;

  aud_ser_mclk #(.DIV(DIV), .SLOT_N(SLOT_N)) u_mclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sleep | ~master_sel),
    .bclk    (m_bclk),
    .ws      (m_ws),
    .tick    (m_tick),
    .ws_next (m_ws_next)
  );

  aud_ser_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .ws_in     (ws_in),
    .fall_tick (s_tick),
    .ws_s      (s_ws)
  );

  assign bit_tick = ~sleep & (master_sel ? m_tick : s_tick);
  assign ws_now   = master_sel ? m_ws_next : s_ws;
  assign swap_pol = ~master_sel & ext_fmt;

  aud_ser_slot #(.WORD_W(WORD_W), .SLOT_N(SLOT_N), .QW(QW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sleep),
    .tick     (bit_tick),
    .ws_now   (ws_now),
    .swap     (swap_pol),
    .aligned  (fmt_sel),
    .left_in  (left_in),
    .right_in (right_in),
    .quiet_n  (hpf_on ? Q_LONG : Q_SHORT),
    .sd       (sd_out),
    .slot_q   (trk_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sd_oe  <= 1'b0;
      pin_clk_oe <= 1'b0;
    end else begin
      pin_sd_oe  <= ~sleep;
      pin_clk_oe <= ~sleep & master_sel;
    end
  end

  assign bclk_out = m_bclk;
  assign ws_out   = m_ws;
  assign bclk_oe  = pin_clk_oe;
  assign ws_oe    = pin_clk_oe;
  assign sd_oe    = pin_sd_oe;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned SLOT_N = 32,
  localparam int unsigned CW    = $clog2(SLOT_N) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          bclk_out,
  input logic          bclk_oe,
  input logic          ws_out,
  input logic          sd_out,
  input logic          sd_oe,
  input logic [CW-1:0] slot_q
);
  AST_SLEEP_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!sd_oe && !bclk_oe)) else $error("pins driven in standby"); // R8

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe && $past(bclk_oe) && !$stable(sd_out)) |-> $fell(bclk_out))
    else $error("data moved off a falling edge"); // R2

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe && $past(bclk_oe) && !$stable(ws_out)) |-> $fell(bclk_out))
    else $error("word select moved off a falling edge"); // R1

  AST_BCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe && $rose(bclk_out)) |=> bclk_out) else $error("bit clock high too short"); // R1

  AST_FILLER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q > CW'(WORD_W)) |-> !sd_out) else $error("filler slot not zero"); // R5

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> !sd_out) else $error("data not quiet on wake"); // R9
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.WORD_W(WORD_W), .SLOT_N(SLOT_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep    (sleep),
  .bclk_out (bclk_out),
  .bclk_oe  (bclk_oe),
  .ws_out   (ws_out),
  .sd_out   (sd_out),
  .sd_oe    (sd_oe),
  .slot_q   (trk_slot)
);

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  localparam int W  = 18;
  localparam int SN = 32;
  localparam int DV = 4;
  localparam int QS = 2;
  localparam int QL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master_sel = 1'b1, fmt_sel = 1'b1, ext_fmt = 1'b0, hpf_on = 1'b0, sleep = 1'b0;
  logic bclk_in = 1'b1, ws_in = 1'b1;
  logic [W-1:0] left_in = '0, right_in = '0;
  logic bclk_out, bclk_oe, ws_out, ws_oe, sd_out, sd_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aud_ser_tx #(.WORD_W(W), .SLOT_N(SN), .DIV(DV), .QUIET_SHORT(QS),
               .QUIET_LONG(QL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .fmt_sel(fmt_sel),
    .ext_fmt(ext_fmt), .hpf_on(hpf_on), .sleep(sleep), .left_in(left_in),
    .right_in(right_in), .bclk_in(bclk_in), .ws_in(ws_in), .bclk_out(bclk_out),
    .bclk_oe(bclk_oe), .ws_out(ws_out), .ws_oe(ws_oe), .sd_out(sd_out), .sd_oe(sd_oe));

  // receiver model state
  int rx_slot = 0, rx_lcount = 0, rx_words = 0, pick = 0;
  bit rx_ws_prev = 1'b1, rx_valid = 1'b0, rx_chan = 1'b0, rx_live = 1'b0;
  logic [W-1:0]  rx_exp = '0;
  logic [SN-1:0] rx_bits = '0;
  bit mon_on = 1'b0, pb = 1'b0, psd = 1'b0, rise_seen = 1'b0;
  int since = 0;

  function automatic void check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // Expected slot pattern: word at the top of the slot, shifted one bit for the delayed layout
  function automatic logic [SN-1:0] frame_of(logic [W-1:0] w, bit aligned);
    logic [SN-1:0] v;
    v = {w, {(SN-W){1'b0}}};
    if (!aligned) v = v >> 1;
    return v;
  endfunction

  function automatic logic [W-1:0] next_sample();
    pick++;
    case (pick)
      1: return 18'h1FFFF;
      2: return 18'h20000;
      3: return '1;
      4: return '0;
      5: return 18'h00001;
      default: return W'($urandom);
    endcase
  endfunction

  function automatic void rx_reset();
    rx_ws_prev = 1'b1; rx_valid = 1'b0; rx_lcount = 0; rx_slot = 0;
    rise_seen = 1'b0; since = 0;
  endfunction

  // One received bit, taken at a rising bit-clock edge
  function automatic void rx_bit(logic sd, logic ws);
    string tg;
    if (ws !== rx_ws_prev) begin
      if (master_sel && rx_valid)
        check(rx_slot == SN-1, "R1 word select period", rx_slot + 1, SN);
      rx_slot = 0; rx_valid = 1'b1; rx_bits = '0;
      rx_chan = ws ^ (!master_sel && ext_fmt);
      if (!rx_chan) rx_lcount++;
      rx_live = rx_lcount > (hpf_on ? QL : QS);
      rx_exp = rx_chan ? right_in : left_in;
      if (rx_chan) left_in = next_sample(); else right_in = next_sample();
    end else begin
      rx_slot++;
    end
    rx_ws_prev = ws;
    if (rx_valid && rx_slot < SN) rx_bits[SN-1-rx_slot] = sd;
    if (rx_valid && rx_slot == SN-1) begin
      if (rx_live)
        tg = $sformatf("%s R5 R6 R10%s channel %0d", fmt_sel ? "R3" : "R4",
                       master_sel ? "" : " R7", rx_chan);
      else
        tg = "R9 quiet channel";
      check(rx_bits == (rx_live ? frame_of(rx_exp, fmt_sel) : '0), tg,
            longint'(rx_bits), longint'(rx_live ? frame_of(rx_exp, fmt_sel) : '0));
      rx_words++;
    end
  endfunction

  // Master-mode pin monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_on && master_sel) begin
      since++;
      if (bclk_out && !pb) begin
        if (rise_seen) check(since == DV, "R1 bit clock period", since, DV);
        rise_seen = 1'b1;
        since = 0;
        rx_bit(sd_out, ws_out);
      end
      if (bclk_oe && !pb && bclk_out && rise_seen && since == 0) begin
      end
      if (sd_oe && sd_out !== psd)
        check(pb && !bclk_out, "R2 data change off falling edge", bclk_out, 0);
    end
    pb  = bclk_out;
    psd = sd_out;
  end

  task automatic do_reset(bit m, bit f, bit e, bit h);
    rst_n = 1'b0;
    master_sel = m; fmt_sel = f; ext_fmt = e; hpf_on = h;
    bclk_in = 1'b1; ws_in = 1'b1; sleep = 1'b0;
    rx_reset();
    repeat (3) @(negedge clk);
    check(!sd_oe && !bclk_oe && !ws_oe && !sd_out, "R8 pins released in reset",
          {sd_oe, bclk_oe, ws_oe, sd_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sd_oe && (bclk_oe == m) && (ws_oe == m) && !sd_out, "R8 pins after reset",
          {sd_oe, bclk_oe, ws_oe, sd_out}, {1'b1, m, m, 1'b0});
  endtask

  task automatic master_run(bit f, bit e, bit h, int frames);
    int target;
    do_reset(1'b1, f, e, h);
    mon_on = 1'b1;
    target = rx_words + 2 * frames;
    wait (rx_words >= target);
    mon_on = 1'b0;
  endtask

  task automatic slave_run(bit f, bit e, bit h, int frames);
    do_reset(1'b0, f, e, h);
    for (int ch = 0; ch < 2 * frames; ch++) begin
      for (int b = 0; b < SN; b++) begin
        @(negedge clk);
        bclk_in = 1'b0;
        if (b == 0) ws_in = ~ws_in;
        repeat (3) @(negedge clk);
        rx_bit(sd_out, ws_in);
        @(negedge clk);
        bclk_in = 1'b1;
        repeat (3) @(negedge clk);
      end
      repeat ($urandom_range(0, 12)) @(negedge clk);   // idle gap, R7
    end
  endtask

  task automatic standby_run();
    int target;
    do_reset(1'b1, 1'b1, 1'b0, 1'b0);
    mon_on = 1'b1;
    target = rx_words + 8;
    wait (rx_words >= target);
    @(negedge clk);
    mon_on = 1'b0;
    sleep = 1'b1;
    rx_reset();
    repeat (3) @(negedge clk);
    check(!sd_oe && !bclk_oe && !ws_oe && !sd_out, "R8 standby pins",
          {sd_oe, bclk_oe, ws_oe, sd_out}, 0);
    repeat (20) @(negedge clk);
    check(!sd_oe && !bclk_oe && !sd_out, "R8 standby held", {sd_oe, bclk_oe, sd_out}, 0);
    sleep = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sd_oe && !sd_out, "R9 wake quiet", {sd_oe, sd_out}, 2'b10);
    mon_on = 1'b1;
    target = rx_words + 2 * (QS + 3);
    wait (rx_words >= target);
    mon_on = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    master_run(1'b1, 1'b0, 1'b0, 6);
    master_run(1'b0, 1'b1, 1'b1, 9);
    slave_run(1'b1, 1'b0, 1'b0, 5);
    slave_run(1'b0, 1'b1, 1'b1, 8);
    slave_run(1'b1, 1'b1, 1'b0, 4);
    standby_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rx_words, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule